// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block sits next to a cache and handles the cache's misses. A miss on block address A that the block cannot serve becomes a demand read to lower memory. The block then starts a stream of prefetches at A+1. Prefetched blocks go into a small FIFO-ordered stream buffer of its own and never into the cache.

Each later miss is compared against the head of the stream buffer before memory is used. If the head holds the missing block, the block comes straight from the buffer and the buffer is topped up with the block after its current tail. If the head does not match, the stream is thrown away and a new one begins after the missing address.

Memory takes one request at a time and returns responses in order. Demand reads always go ahead of queued prefetches.

Top module: `stream_prefetch`

## Requirements
- R1: After reset `missReady` is 1 and `respValid` and `memReqValid` are 0. The buffer holds nothing, so the first miss always goes to memory.
- R2: A miss that does not match the buffer head is sent to memory as a demand read for that address. The returned block appears on `respAddr`/`respData` with `respValid` high for exactly one cycle.
- R3: After a miss at A is served from memory, the blocks A+1, A+2, A+3, A+4 (DEPTH=4) are read from memory in ascending order, and each is read only once.
- R4: A miss whose address equals the head tag, when the head data is present, is answered in the cycle right after the miss is accepted, with no memory request for that address.
- R5: Only one miss is in service at a time. `missReady` is 0 from the cycle after acceptance until the response cycle has ended.
- R6: When a demand read and a prefetch are both waiting for the memory port, `memReqAddr` carries the demand address.
- R7: A miss on the head block while that block's prefetch is still queued or in flight is answered when the prefetched data arrives. That address is requested from memory exactly once.
- R8: A miss that does not match the head flushes the buffer. Data returning from a prefetch that was in flight at the flush is never delivered for the new stream.
- R9: Each block taken from the head triggers one prefetch of the block that follows the current tail, which is the old head address plus DEPTH.
- R10: Block addresses wrap modulo 2^ADDR_W, so the block after the all-ones address is block 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| missValid | input | 1 | Cache miss request valid |
| missAddr | input | ADDR_W | Block address that missed |
| missReady | output | 1 | Block can accept a miss |
| respValid | output | 1 | One-cycle pulse: block returned to the cache |
| respAddr | output | ADDR_W | Address of the returned block |
| respData | output | DATA_W | Returned block data |
| memReqValid | output | 1 | Read request to lower memory |
| memReqReady | input | 1 | Lower memory accepts the request |
| memReqAddr | output | ADDR_W | Requested block address |
| memRespValid | input | 1 | Read data valid, in request order |
| memRespData | input | DATA_W | Read data |

## Verification
The bench goes after misses that land on the head while its prefetch is still in flight. A design that gets this wrong would request the block a second time or hand back an empty entry.

It also flushes the stream while a prefetch is outstanding and then hits the slot that prefetch would have filled. Stale data leaking from the old stream shows up there as the wrong `respData`.

With the memory port held off, it checks that a fresh demand address, and not the queued tail prefetch, is the one offered. Sequential runs at several memory latencies, and a run that crosses the address wrap, catch duplicate or skipped prefetches and a bad tail address.

// File: rtl/spf_pkg.sv
package spf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DWAIT,
    ST_HWAIT,
    ST_RESP
  } spfState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic flush;     // discard stream, start a new one after missAddr
    logic pop;       // take head entry, append block after tail
    logic pfIssue;   // prefetch request accepted by memory
    logic fillPf;    // prefetch data arrived for a live slot
    logic loadHead;  // response taken from buffer head
    logic loadMem;   // response taken from demand read data
  } spfStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic headHit;
    logic headValid;
    logic pfPending;
  } spfStat_t;

endpackage

// File: rtl/spf_data.sv
module spf_data
  import spf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  spfStrobe_t        strb,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic [DATA_W-1:0] memRespData,
  output spfStat_t          stat,
  output logic [ADDR_W-1:0] pfAddr,
  output logic [ADDR_W-1:0] dmdAddr,
  output logic [ADDR_W-1:0] respAddr,
  output logic [DATA_W-1:0] respData
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] tagQ  [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];
  logic              vld   [DEPTH];
  logic [DEPTH-1:0]  vldVec;
  logic [PW-1:0]     headPtr, outSlot, issueSlot, headNx;
  logic [CW-1:0]     issueCnt;
  logic [CW:0]       slotSum;
  logic [ADDR_W-1:0] nextAddr;
  logic              live;

  // slot of the oldest entry not yet requested from memory
  always_comb begin
    slotSum   = (CW+1)'(headPtr) + (CW+1)'(issueCnt);
    issueSlot = (slotSum >= (CW+1)'(DEPTH)) ? PW'(slotSum - (CW+1)'(DEPTH)) : PW'(slotSum);
    headNx    = (headPtr == PW'(DEPTH-1)) ? '0 : headPtr + PW'(1);
  end

  always_comb begin
    stat.headHit   = live && (tagQ[headPtr] == missAddr);
    stat.headValid = live && vld[headPtr];
    stat.pfPending = live && (issueCnt != CW'(DEPTH));
    pfAddr         = tagQ[issueSlot];
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : gEntry
      assign vldVec[g] = vld[g];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tagQ[g]  <= '0;
          dataQ[g] <= '0;
          vld[g]   <= 1'b0;
        end else if (strb.flush) begin
          tagQ[g] <= missAddr + ADDR_W'(g + 1);
          vld[g]  <= 1'b0;
        end else begin
          if (strb.fillPf && outSlot == PW'(g)) begin
            dataQ[g] <= memRespData;
            vld[g]   <= 1'b1;
          end
          if (strb.pop && headPtr == PW'(g)) begin
            tagQ[g] <= nextAddr;
            vld[g]  <= 1'b0;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      headPtr  <= '0;
      issueCnt <= '0;
      nextAddr <= '0;
      live     <= 1'b0;
      outSlot  <= '0;
      dmdAddr  <= '0;
    end else if (strb.flush) begin
      headPtr  <= '0;
      issueCnt <= '0;
      nextAddr <= missAddr + ADDR_W'(DEPTH + 1);
      live     <= 1'b1;
      dmdAddr  <= missAddr;
    end else begin
      if (strb.pop) begin
        headPtr  <= headNx;
        nextAddr <= nextAddr + ADDR_W'(1);
      end
      issueCnt <= issueCnt + CW'(strb.pfIssue) - CW'(strb.pop);
      if (strb.pfIssue) outSlot <= issueSlot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respAddr <= '0;
      respData <= '0;
    end else if (strb.loadHead) begin
      respAddr <= tagQ[headPtr];
      respData <= dataQ[headPtr];
    end else if (strb.loadMem) begin
      respAddr <= dmdAddr;
      respData <= memRespData;
    end
  end

  // a pop may only take an entry whose data has arrived
  assert_pop_head_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pop |-> vld[headPtr]);

  // a prefetch is only granted while an unrequested entry exists
  assert_issue_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pfIssue |-> (issueCnt < CW'(DEPTH)));

  // after a flush no entry holds data, including late prefetch fills
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.flush |=> (vldVec == '0) && live);

endmodule

// File: rtl/spf_ctrl.sv
module spf_ctrl
  import spf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       missValid,
  output logic       missReady,
  input  spfStat_t   stat,
  input  logic       memReqReady,
  input  logic       memRespValid,
  output logic       memReqValid,
  output logic       dmdSel,
  output logic       respValid,
  output spfStrobe_t strb
);

  spfState_t state, stateNx;
  logic outstanding, outIsDmd, drop;
  logic accept, takeHead, pfReq, respIn;

  always_comb begin
    accept   = (state == ST_IDLE) && missValid;
    takeHead = ((accept && stat.headHit) || state == ST_HWAIT) && stat.headValid;
    dmdSel   = (state == ST_DREQ) && !outstanding;
    // prefetches yield to a waiting demand and to a miss being decided
    pfReq    = stat.pfPending && !outstanding && (state != ST_DREQ) && !accept;
    respIn   = memRespValid && outstanding;

    memReqValid   = dmdSel || pfReq;
    missReady     = (state == ST_IDLE);
    respValid     = (state == ST_RESP);

    strb.flush    = accept && !stat.headHit;
    strb.pop      = takeHead;
    strb.loadHead = takeHead;
    strb.pfIssue  = pfReq && memReqReady;
    strb.loadMem  = respIn && outIsDmd;
    strb.fillPf   = respIn && !outIsDmd && !drop && !strb.flush;
  end

  always_comb begin
    stateNx = state;
    unique case (state)
      ST_IDLE:  if (accept) stateNx = stat.headHit ? (stat.headValid ? ST_RESP : ST_HWAIT) : ST_DREQ;
      ST_DREQ:  if (memReqReady) stateNx = outstanding ? ST_DREQ : ST_DWAIT;
      ST_DWAIT: if (strb.loadMem) stateNx = ST_RESP;
      ST_HWAIT: if (stat.headValid) stateNx = ST_RESP;
      ST_RESP:  stateNx = ST_IDLE;
      default:  stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      outstanding <= 1'b0;
      outIsDmd    <= 1'b0;
      drop        <= 1'b0;
    end else begin
      state <= stateNx;
      if (memReqValid && memReqReady) begin
        outstanding <= 1'b1;
        outIsDmd    <= dmdSel;
      end else if (respIn) begin
        outstanding <= 1'b0;
      end
      if (strb.flush && outstanding && !respIn) drop <= 1'b1;
      else if (respIn) drop <= 1'b0;
    end
  end

  assert_resp_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |=> !respValid && missReady);

  assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (missValid && missReady) |=> !missReady);

  assert_flush_to_demand_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.flush |=> (state == ST_DREQ) && !(memReqValid && !dmdSel));

endmodule

// File: rtl/stream_prefetch.sv
module stream_prefetch
  import spf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  output logic              missReady,
  output logic              respValid,
  output logic [ADDR_W-1:0] respAddr,
  output logic [DATA_W-1:0] respData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRespValid,
  input  logic [DATA_W-1:0] memRespData
);

  spfStrobe_t        strb;
  spfStat_t          stat;
  logic              dmdSel;
  logic [ADDR_W-1:0] pfAddr, dmdAddr;

  spf_ctrl uCtrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .missValid   (missValid),
    .missReady   (missReady),
    .stat        (stat),
    .memReqReady (memReqReady),
    .memRespValid(memRespValid),
    .memReqValid (memReqValid),
    .dmdSel      (dmdSel),
    .respValid   (respValid),
    .strb        (strb)
  );

  spf_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .missAddr    (missAddr),
    .memRespData (memRespData),
    .stat        (stat),
    .pfAddr      (pfAddr),
    .dmdAddr     (dmdAddr),
    .respAddr    (respAddr),
    .respData    (respData)
  );

  assign memReqAddr = dmdSel ? dmdAddr : pfAddr;

endmodule

// File: tb/tb_stream_prefetch.sv
module tb_stream_prefetch;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, missValid, missReady, respValid, memReqValid, memReqReady, memRespValid;
  logic [AW-1:0] missAddr, respAddr, memReqAddr;
  logic [DW-1:0] respData, memRespData;

  stream_prefetch dut (
    .clk(clk), .rst_n(rst_n), .missValid(missValid), .missAddr(missAddr),
    .missReady(missReady), .respValid(respValid), .respAddr(respAddr),
    .respData(respData), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRespValid(memRespValid), .memRespData(memRespData)
  );

  int checks = 0, fails = 0, cyc = 0;
  int memLat = 3;
  bit readyEn = 1'b1;
  logic [AW-1:0] reqLog [0:511];
  int logCnt = 0;
  bit pend = 1'b0;
  int timer = 0;
  logic [AW-1:0] pendA = '0;

  function automatic logic [DW-1:0] dataOf(input logic [AW-1:0] a);
    return {a, a ^ 16'h5A3C};
  endfunction

  function automatic int reqCount(input logic [AW-1:0] a);
    int n = 0;
    for (int i = 0; i < logCnt; i++) if (reqLog[i] == a) n++;
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: in order, one request at a time, fixed latency
  always @(negedge clk) begin
    cyc++;
    memRespValid = 1'b0;
    if (pend) begin
      if (timer == 0) begin
        memRespValid = 1'b1;
        memRespData  = dataOf(pendA);
        pend = 1'b0;
      end else timer--;
    end
    memReqReady = readyEn;
    if (rst_n && memReqValid && memReqReady) begin
      if (logCnt < 512) reqLog[logCnt] = memReqAddr;
      logCnt++;
      pendA = memReqAddr;
      timer = memLat - 1;
      pend  = 1'b1;
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic issueMiss(input logic [AW-1:0] a);
    int w = 0;
    while (!missReady && w < 2000) begin @(negedge clk); w++; end
    @(posedge clk); #1;
    missValid = 1'b1; missAddr = a;
    @(posedge clk); #1;
    missValid = 1'b0;
    @(negedge clk);
    chk(missReady == 1'b0, "R5 busy after accept", missReady, 0);
  endtask

  task automatic waitResp(input logic [AW-1:0] a, input string req, output int lat);
    lat = 1;
    while (!respValid && lat < 2000) begin @(negedge clk); lat++; end
    chk(respAddr == a, {req, " addr"}, respAddr, a);
    chk(respData == dataOf(a), {req, " data"}, respData, dataOf(a));
    @(negedge clk);
    chk(respValid == 1'b0, "R2 single-cycle pulse", respValid, 0);
  endtask

  task automatic doMiss(input logic [AW-1:0] a, input string req, output int lat);
    issueMiss(a);
    waitResp(a, req, lat);
  endtask

  task automatic quiesce();
    repeat (memLat * 6 + 20) @(negedge clk);
  endtask

  initial begin
    int lat;
    logic [AW-1:0] a, d, e, f, g, s;
    rst_n = 1'b0; missValid = 1'b0; missAddr = '0;
    memRespValid = 1'b0; memRespData = '0; memReqReady = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(missReady == 1'b1, "R1 missReady", missReady, 1);
    chk(respValid == 1'b0, "R1 respValid", respValid, 0);
    chk(memReqValid == 1'b0, "R1 memReqValid", memReqValid, 0);

    // cold miss, then stream fill
    a = 16'h0100; logCnt = 0;
    doMiss(a, "R2 cold miss", lat);
    chk(lat > 1, "R1 first miss goes to memory", lat, 2);
    chk(reqLog[0] == a, "R2 demand first", reqLog[0], a);
    quiesce();
    chk(logCnt == 5, "R3 request count", logCnt, 5);
    for (int k = 1; k <= 4; k++)
      chk(reqLog[k] == a + AW'(k), "R3 ascending prefetch", reqLog[k], a + AW'(k));

    // head hit with data present
    logCnt = 0;
    doMiss(a + 1, "R4 head hit", lat);
    chk(lat == 1, "R4 hit latency", lat, 1);
    quiesce();
    chk(reqCount(a + 1) == 0, "R4 no memory read", reqCount(a + 1), 0);
    chk(reqCount(a + 5) == 1, "R9 tail prefetch", reqCount(a + 5), 1);
    chk(logCnt == 1, "R9 one refill", logCnt, 1);

    // demand priority over a queued tail prefetch
    readyEn = 1'b0;
    doMiss(a + 2, "R4 hit under stall", lat);
    chk(lat == 1, "R4 hit latency under stall", lat, 1);
    chk(memReqValid && memReqAddr == a + 6, "R9 tail prefetch offered", memReqAddr, a + 6);
    d = 16'h0800;
    issueMiss(d);
    repeat (2) @(negedge clk);
    chk(memReqValid && memReqAddr == d, "R6 demand wins", memReqAddr, d);
    readyEn = 1'b1;
    waitResp(d, "R6 demand response", lat);
    quiesce();

    // head hit while its prefetch is in flight
    memLat = 12; logCnt = 0;
    e = 16'h1000;
    doMiss(e, "R7 lead miss", lat);
    doMiss(e + 1, "R7 in-flight hit", lat);
    chk(lat > 1, "R7 waited for data", lat, 2);
    quiesce();
    chk(reqCount(e + 1) == 1, "R7 requested once", reqCount(e + 1), 1);

    // flush while a prefetch is in flight; stale data must not leak
    memLat = 10;
    f = 16'h2000; g = 16'h3000;
    doMiss(f, "R8 first stream", lat);
    doMiss(g, "R8 flushing miss", lat);
    doMiss(g + 1, "R8 new stream head", lat);
    quiesce();

    // address wrap
    memLat = 2;
    doMiss(16'hFFFE, "R10 near top", lat);
    quiesce();
    doMiss(16'hFFFF, "R10 top block", lat);
    chk(lat == 1, "R10 hit top", lat, 1);
    doMiss(16'h0000, "R10 wrapped block", lat);
    chk(lat == 1, "R10 hit wrapped", lat, 1);
    doMiss(16'h0001, "R10 after wrap", lat);
    quiesce();

    // sequential sweeps at several latencies
    for (int li = 0; li < 3; li++) begin
      memLat = (li == 0) ? 1 : (li == 1) ? 2 : 5;
      s = 16'h4000 + AW'(li * 16'h0100);
      quiesce();
      logCnt = 0;
      for (int k = 0; k < 10; k++) doMiss(s + AW'(k), "R3 sweep", lat);
      quiesce();
      for (int k = 0; k < 14; k++)
        chk(reqCount(s + AW'(k)) == 1, "R7 each block read once", reqCount(s + AW'(k)), 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule